// File: doc/BRIEF.md
# Stereo DAC Attenuation Code Writer

This block turns one playback channel's volume setting into a logarithmic attenuation code for a codec DAC and sends it to the codec's control port. Each request carries a channel index, a 7-bit channel volume with a mute flag, and two 7-bit master volumes, each with its own mute flag. One master serves the even-indexed channels and the other serves the odd-indexed channels. The block multiplies the channel volume by the selected master volume and scales the product back to the volume range. It looks the result up in a decibel table and inverts the table value, so that a larger code means a louder output.

The code goes out as two register writes to the same codec address. The first write stages the value without its update flags. The second write repeats the value with both update flags set, so the codec applies it. Writes leave through a request/acknowledge handshake to a downstream serializer. The block takes a new request only while it is idle.

Top module: `dac_gain_writer`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `wr_req_o` is low. Reset leaves the block idle.
- R2: If the channel mute flag is set, or the mute flag of the selected master is set, the code written is 0.
- R3: Otherwise the index is floor(chan_vol × master_vol / 127), kept to 8 bits. The code is 127 − T(index), where T(0) = 127 and T(x) = floor(20·log10(255/x)) for x ≥ 1. For example, index 127 gives code 121, index 1 gives code 79, and index 0 gives code 0.
- R4: An even channel index (bit 0 = 0) uses master 0 (`mst0_*`). An odd channel index uses master 1 (`mst1_*`).
- R5: Both writes go to address ATT_BASE + channel index. ATT_BASE defaults to 0.
- R6: The first write's data has bits 8:7 = 00 and bits 6:0 = code. The second write's data has bits 8:7 = 11 and the same code in bits 6:0.
- R7: When `start_i` is high in a cycle where `busy_o` is low, `busy_o` and `wr_req_o` are both high in the next cycle.
- R8: While `wr_req_o` is high and `wr_ack_i` is low, the request, the address and the data hold steady into the next cycle.
- R9: `start_i` has no effect while `busy_o` is high. This includes the cycle of the final acknowledge. Input changes during that time do not alter the pending writes.
- R10: Each accepted request produces exactly two writes. `busy_o` is low in the cycle after the second acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| chan_i | input | CH_W (3) | DAC channel index |
| chan_vol_i | input | VOL_W (7) | Channel volume |
| chan_mute_i | input | 1 | Channel mute flag |
| mst0_vol_i | input | VOL_W (7) | Master volume for even channels |
| mst0_mute_i | input | 1 | Mute flag for even-channel master |
| mst1_vol_i | input | VOL_W (7) | Master volume for odd channels |
| mst1_mute_i | input | 1 | Mute flag for odd-channel master |
| wr_ack_i | input | 1 | Serializer accepts the current write |
| busy_o | output | 1 | Request in progress |
| wr_req_o | output | 1 | Write request valid |
| wr_addr_o | output | ADDR_W (7) | Codec register address |
| wr_data_o | output | DATA_W (9) | Codec register data |

## Verification
Two events can land in the same cycle: the acknowledge that completes the second write, and a fresh start strobe. The bench provokes this by raising `start_i` together with the final `wr_ack_i`, using different input values. It then requires `busy_o` and `wr_req_o` to be low in the following two cycles, so the strobe must have been dropped.

The bench also raises start strobes and changes the input values while writes are waiting for acknowledgement. For these it checks that both writes still carry the address and code of the original request.

// File: rtl/gainmap_pkg.sv
package gainmap_pkg;

    // Write sequencer phases: idle, staging write, commit write
    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_STAGE  = 2'd1,
        WS_COMMIT = 2'd2
    } wr_state_e;

endpackage

// File: rtl/gain_index.sv
module gain_index #(
    parameter int VOL_W = 7,
    parameter int IDX_W = 8
) (
    input  logic [VOL_W-1:0] chan_vol_i,
    input  logic             chan_mute_i,
    input  logic [VOL_W-1:0] mst_vol_i,
    input  logic             mst_mute_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             mute_o
);
    localparam int PROD_W = 2 * VOL_W;
    localparam int VMAX   = (1 << VOL_W) - 1;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    // Scale the product back to the volume range, then keep the low index bits
    always_comb begin
        prod   = PROD_W'(chan_vol_i) * PROD_W'(mst_vol_i);
        quot   = prod / PROD_W'(VMAX);
        idx_o  = quot[IDX_W-1:0];
        mute_o = chan_mute_i | mst_mute_i;
    end

endmodule

// File: rtl/atten_lut.sv
module atten_lut #(
    parameter int IDX_W      = 8,
    parameter int CODE_W     = 7,
    parameter int FULL_SCALE = 255
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    // Largest index that still reaches k whole decibels below full scale
    function automatic int thr_of(input int k);
        return $rtoi(real'(FULL_SCALE) / (10.0 ** (real'(k) / 20.0)));
    endfunction

    // Number of decibel steps with a nonzero threshold
    function automatic int count_steps();
        int k;
        k = 0;
        while (thr_of(k + 1) >= 1) k++;
        return k;
    endfunction

    localparam int STEPS = count_steps();

    logic [STEPS-1:0]  hit;
    logic [CODE_W-1:0] entry;

    // One comparator per decibel step; the table value is the count of hits
    for (genvar g = 0; g < STEPS; g++) begin : g_step
        localparam int THR = thr_of(g + 1);
        assign hit[g] = (int'(idx_i) <= THR);
    end

    always_comb begin
        entry = '0;
        for (int k = 0; k < STEPS; k++) begin
            entry = entry + CODE_W'(hit[k]);
        end
        if (idx_i == '0) begin
            entry = CODE_W'(CODE_MAX);
        end
        code_o = CODE_W'(CODE_MAX) - entry;
    end

endmodule

// File: rtl/dac_gain_writer.sv
module dac_gain_writer
    import gainmap_pkg::*;
#(
    parameter int CH_W       = 3,
    parameter int VOL_W      = 7,
    parameter int IDX_W      = 8,
    parameter int CODE_W     = 7,
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 9,
    parameter int ATT_BASE   = 0,
    parameter int FULL_SCALE = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic [VOL_W-1:0]  chan_vol_i,
    input  logic              chan_mute_i,
    input  logic [VOL_W-1:0]  mst0_vol_i,
    input  logic              mst0_mute_i,
    input  logic [VOL_W-1:0]  mst1_vol_i,
    input  logic              mst1_mute_i,
    input  logic              wr_ack_i,
    output logic              busy_o,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam int UPD_W = DATA_W - CODE_W;

    typedef struct packed {
        wr_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] code;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [VOL_W-1:0]  mst_vol;
    logic              mst_mute;
    logic [IDX_W-1:0]  idx;
    logic              muted;
    logic [CODE_W-1:0] lut_code;

    // Master selection by channel parity
    always_comb begin
        mst_vol  = chan_i[0] ? mst1_vol_i  : mst0_vol_i;
        mst_mute = chan_i[0] ? mst1_mute_i : mst0_mute_i;
    end

    gain_index #(
        .VOL_W (VOL_W),
        .IDX_W (IDX_W)
    ) u_idx (
        .chan_vol_i  (chan_vol_i),
        .chan_mute_i (chan_mute_i),
        .mst_vol_i   (mst_vol),
        .mst_mute_i  (mst_mute),
        .idx_o       (idx),
        .mute_o      (muted)
    );

    atten_lut #(
        .IDX_W      (IDX_W),
        .CODE_W     (CODE_W),
        .FULL_SCALE (FULL_SCALE)
    ) u_lut (
        .idx_i  (idx),
        .code_o (lut_code)
    );

    // Next-state computation
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            WS_IDLE: begin
                if (start_i) begin
                    seq_d.st   = WS_STAGE;
                    seq_d.addr = ADDR_W'(ATT_BASE) + ADDR_W'(chan_i);
                    seq_d.code = muted ? '0 : lut_code;
                end
            end
            WS_STAGE: begin
                if (wr_ack_i) seq_d.st = WS_COMMIT;
            end
            WS_COMMIT: begin
                if (wr_ack_i) seq_d.st = WS_IDLE;
            end
            default: seq_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: WS_IDLE, addr: '0, code: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        busy_o    = (seq_q.st != WS_IDLE);
        wr_req_o  = busy_o;
        wr_addr_o = seq_q.addr;
        wr_data_o = {{UPD_W{seq_q.st == WS_COMMIT}}, seq_q.code};
    end

endmodule

// File: rtl/gain_writer_chk.sv
module gain_writer_chk #(
    parameter int CH_W     = 3,
    parameter int CODE_W   = 7,
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 9,
    parameter int ATT_BASE = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CH_W-1:0]   chan_i,
    input logic              wr_ack_i,
    input logic              busy_o,
    input logic              wr_req_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [DATA_W-1:0] wr_data_o
);
    logic              second_q;
    logic [CH_W-1:0]   chan_q;
    logic [CODE_W-1:0] first_code_q;

    // Observer state built only from port traffic
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            second_q     <= 1'b0;
            chan_q       <= '0;
            first_code_q <= '0;
        end else begin
            if (start_i && !busy_o) chan_q <= chan_i;
            if (wr_req_o && wr_ack_i) begin
                second_q <= !second_q;
                if (!second_q) first_code_q <= wr_data_o[CODE_W-1:0];
            end
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_req_o);

    assert_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && wr_req_o));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    assert_stage_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !second_q) |-> (wr_data_o[DATA_W-1:CODE_W] == '0));

    assert_commit_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && second_q) |-> ((wr_data_o[DATA_W-1:CODE_W] == '1)
                                    && (wr_data_o[CODE_W-1:0] == first_code_q)));

    assert_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (wr_addr_o == ADDR_W'(ATT_BASE) + ADDR_W'(chan_q)));

    assert_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_ack_i && second_q) |=> !busy_o);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !(wr_ack_i && second_q)) |=> busy_o);

endmodule

bind dac_gain_writer gain_writer_chk #(
    .CH_W     (CH_W),
    .CODE_W   (CODE_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ATT_BASE (ATT_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .chan_i    (chan_i),
    .wr_ack_i  (wr_ack_i),
    .busy_o    (busy_o),
    .wr_req_o  (wr_req_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
);

// File: tb/sim_dac_gain_writer.sv
module sim_dac_gain_writer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic [6:0] chan_vol_i = '0;
    logic       chan_mute_i = 1'b0;
    logic [6:0] mst0_vol_i = '0;
    logic       mst0_mute_i = 1'b0;
    logic [6:0] mst1_vol_i = '0;
    logic       mst1_mute_i = 1'b0;
    logic       wr_ack_i = 1'b0;
    logic       busy_o;
    logic       wr_req_o;
    logic [6:0] wr_addr_o;
    logic [8:0] wr_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dac_gain_writer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .chan_i      (chan_i),
        .chan_vol_i  (chan_vol_i),
        .chan_mute_i (chan_mute_i),
        .mst0_vol_i  (mst0_vol_i),
        .mst0_mute_i (mst0_mute_i),
        .mst1_vol_i  (mst1_vol_i),
        .mst1_mute_i (mst1_mute_i),
        .wr_ack_i    (wr_ack_i),
        .busy_o      (busy_o),
        .wr_req_o    (wr_req_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Expected code from the requirement formulas
    function automatic logic [6:0] exp_code(input int cv, input bit cm, input int mv, input bit mm);
        int idx;
        int ent;
        if (cm || mm) return 7'd0;
        idx = ((cv * mv) / 127) & 255;
        if (idx == 0) ent = 127;
        else ent = $rtoi($floor(20.0 * $log10(255.0 / real'(idx))));
        return 7'(127 - ent);
    endfunction

    task automatic scramble_inputs();
        chan_i      = 3'($urandom);
        chan_vol_i  = 7'($urandom);
        chan_mute_i = 1'($urandom);
        mst0_vol_i  = 7'($urandom);
        mst1_vol_i  = 7'($urandom);
    endtask

    task automatic wait_ack(input int dly, input logic [6:0] ea, input logic [8:0] ed, input string tag);
        for (int i = 0; i < dly; i++) begin
            start_i = 1'($urandom);
            scramble_inputs();
            @(negedge clk);
            check(wr_req_o && wr_addr_o == ea && wr_data_o == ed,
                  {tag, " R8/R9 held"}, int'({wr_req_o, wr_addr_o, wr_data_o}), int'({1'b1, ea, ed}));
        end
        start_i = 1'b0;
    endtask

    task automatic run_req(input int ch, input int cv, input bit cm, input int v0, input bit m0,
                           input int v1, input bit m1, input int d1, input int d2,
                           input bit collide, input string tag);
        logic [6:0] ec;
        logic [6:0] ea;
        ec = (ch % 2 == 1) ? exp_code(cv, cm, v1, m1) : exp_code(cv, cm, v0, m0);
        ea = 7'(ch);
        @(negedge clk);
        chan_i = 3'(ch); chan_vol_i = 7'(cv); chan_mute_i = cm;
        mst0_vol_i = 7'(v0); mst0_mute_i = m0; mst1_vol_i = 7'(v1); mst1_mute_i = m1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && wr_req_o, "R7 launch", int'({busy_o, wr_req_o}), 3);
        check(wr_addr_o == ea, {tag, " R5 addr"}, int'(wr_addr_o), int'(ea));
        check(wr_data_o == {2'b00, ec}, {tag, " R6 stage data"}, int'(wr_data_o), int'({2'b00, ec}));
        wait_ack(d1, ea, {2'b00, ec}, tag);
        wr_ack_i = 1'b1;
        @(negedge clk);
        wr_ack_i = 1'b0;
        check(wr_req_o && wr_addr_o == ea, {tag, " R5 second addr"}, int'(wr_addr_o), int'(ea));
        check(wr_data_o == {2'b11, ec}, {tag, " R6 commit data"}, int'(wr_data_o), int'({2'b11, ec}));
        wait_ack(d2, ea, {2'b11, ec}, tag);
        wr_ack_i = 1'b1;
        if (collide) begin
            start_i = 1'b1;
            scramble_inputs();
        end
        @(negedge clk);
        wr_ack_i = 1'b0;
        start_i = 1'b0;
        check(!busy_o && !wr_req_o, "R10 done after second ack", int'({busy_o, wr_req_o}), 0);
        @(negedge clk);
        check(!busy_o && !wr_req_o, "R9 no third write", int'({busy_o, wr_req_o}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!busy_o && !wr_req_o, "R1 during reset", int'({busy_o, wr_req_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !wr_req_o, "R1 after reset", int'({busy_o, wr_req_o}), 0);

        // Directed corner cases with literal expected codes
        check(exp_code(127, 0, 127, 0) == 7'd121, "R3 model idx127", int'(exp_code(127, 0, 127, 0)), 121);
        check(exp_code(1, 0, 127, 0) == 7'd79, "R3 model idx1", int'(exp_code(1, 0, 127, 0)), 79);
        run_req(0, 127, 0, 127, 0, 0, 1, 0, 0, 0, "R3 full scale");
        run_req(3, 1, 0, 0, 1, 127, 0, 1, 2, 0, "R3 index one odd R4");
        run_req(4, 0, 0, 127, 0, 127, 0, 0, 1, 1, "R3 zero volume");
        run_req(5, 100, 1, 90, 0, 90, 0, 2, 0, 1, "R2 channel mute");
        run_req(2, 100, 0, 90, 1, 90, 0, 0, 0, 0, "R2 master mute even R4");
        run_req(1, 100, 0, 90, 1, 60, 0, 3, 3, 1, "R4 odd ignores master 0");
        run_req(6, 80, 0, 40, 0, 127, 1, 1, 1, 0, "R4 even ignores master 1");

        // Random traffic
        for (int n = 0; n < 60; n++) begin
            run_req(int'($urandom % 8), int'($urandom % 128), ($urandom % 8) == 0,
                    int'($urandom % 128), ($urandom % 8) == 0,
                    int'($urandom % 128), ($urandom % 8) == 0,
                    int'($urandom % 4), int'($urandom % 4), 1'($urandom),
                    "R3 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule